// File: doc/BRIEF.md
# Audio Programmed-I/O Byte Sequencer

This block is the host data path for byte-at-a-time programmed-I/O transfers to and from a stereo audio codec. It keeps one byte pointer for playback and one for capture. Status bits tell the host which byte of the current sample frame it must write next, and which byte is waiting to be read. The formats are 8-bit or 16-bit samples in mono or stereo, plus packed 4-bit ADPCM at four bytes per set. In the ADPCM format the two status bits act as a byte index into the set.

A single data address serves both directions. A host write fills the next playback byte lane, and a host read returns the capture byte under the capture pointer. A sample-rate strobe in each direction moves a whole frame. On playback it hands the completed frame to the converter side. On capture it loads a freshly converted frame. A strobe that finds the playback frame incomplete is an underrun. A strobe that finds the capture frame still unread is an overrun. Each such event raises a sticky flag for its direction and also the combined error bit. While the codec is held in initialization or power-down, all state is cleared, writes are dropped and reads return a fixed idle byte.

Top module: `pio_seq_stat`

## Requirements
- R1: Playback status. For byte index i of the frame the host must write next, the codes (play_lr, play_ul) are:
  - 8-bit mono: (1,1).
  - 8-bit stereo: lr = 1 only for i=0, and ul = 1.
  - 16-bit mono: lr = 1 and ul = i[0].
  - 16-bit stereo and ADPCM: lr = 1 for i<2 and ul = i[0]. This gives the orders left-lower, left-upper, right-lower, right-upper, and ADPCM bytes 1, 2, 3, 4.
- R2: cap_lr and cap_ul use the R1 encoding for the capture byte currently waiting to be read.
- R3: play_rdy is 1 when playback is enabled, the block is not held and the frame is incomplete. It drops to 0 after the last byte is written. A play_strobe then pulses play_vld for one cycle, starting at the next edge. With that pulse, play_frame carries byte i in bits [8i+7:8i] and zeros in the unused lanes, and play_rdy returns to 1.
- R4: The frame length in bytes is 1 (8-bit mono), 2 (8-bit stereo or 16-bit mono) or 4 (16-bit stereo or ADPCM). The pointer wraps to byte 0 after the last byte.
- R5: When capture is enabled, cap_strobe loads cap_frame and sets cap_rdy. Each read while cap_rdy is 1 returns lane i of the frame and advances the pointer. After the last byte, cap_rdy is 0 and reads return lane 0 without advancing the pointer.
- R6: A play_strobe with playback enabled and the frame incomplete sets err_play and smp_err. The partial frame is discarded, play_vld stays 0 and the pointer restarts at byte 0.
- R7: A cap_strobe with capture enabled while cap_rdy is 1 sets err_cap and smp_err. The new frame replaces the old one and the pointer restarts at byte 0.
- R8: The error flags are sticky, and stat_wr clears them. If stat_wr and a new error occur in the same cycle, the new error wins.
- R9: While hold is 1:
  - host_rdata reads 8'h80;
  - both ready bits read 0;
  - writes and strobes are ignored;
  - pointers, frames and error flags are cleared.
- R10: A host write while play_rdy is 0 changes nothing. A write in the same cycle as a play_strobe is dropped.
- R11: A strobe to a disabled direction has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold | input | 1 | Initialization or power-down hold |
| fmt_adpcm | input | 1 | 1 selects the packed ADPCM format |
| fmt_wide | input | 1 | 1 selects 16-bit samples |
| fmt_stereo | input | 1 | 1 selects stereo |
| play_en | input | 1 | Playback enable |
| cap_en | input | 1 | Capture enable |
| play_strobe | input | 1 | Playback sample-period pulse |
| cap_strobe | input | 1 | Capture sample-period pulse |
| cap_frame | input | 32 | Converted capture frame, lane i in bits [8i+7:8i] |
| host_wr | input | 1 | Host write to the data address |
| host_rd | input | 1 | Host read from the data address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| stat_wr | input | 1 | Host write to status, clears errors |
| play_rdy | output | 1 | Playback wants a byte |
| play_lr | output | 1 | Playback left/right code |
| play_ul | output | 1 | Playback upper/lower code |
| cap_rdy | output | 1 | Fresh capture byte waiting |
| cap_lr | output | 1 | Capture left/right code |
| cap_ul | output | 1 | Capture upper/lower code |
| smp_err | output | 1 | Combined sample error |
| err_play | output | 1 | Sticky playback underrun flag |
| err_cap | output | 1 | Sticky capture overrun flag |
| play_frame | output | 32 | Completed playback frame |
| play_vld | output | 1 | One-cycle pulse when play_frame is handed over |

## Verification
The hardest state to reach is a pointer that restarts in the middle of a frame. Underrun, overrun and release from hold each leave the pointer partly advanced and must restart it at byte 0. The stimulus drives the pointer part-way with one or two host accesses and then fires a strobe or raises hold. It then reads the status code of byte 0 and completes a full frame, whose contents show that no earlier byte survived. The format sweep visits each of the five frame shapes in both directions before these cases run.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
   typedef enum logic [2:0] {
      FMT_B8_MONO,
      FMT_B8_STEREO,
      FMT_B16_MONO,
      FMT_B16_STEREO,
      FMT_PACK4
   } fmt_e;

   // number of bytes in one frame for a format
   function automatic logic [2:0] frame_len(input fmt_e f);
      case (f)
         FMT_B8_MONO:   frame_len = 3'd1;
         FMT_B8_STEREO: frame_len = 3'd2;
         FMT_B16_MONO:  frame_len = 3'd2;
         default:       frame_len = 3'd4;
      endcase
   endfunction

   // {left/right, upper/lower} status code for byte index idx
   function automatic logic [1:0] lane_code(input fmt_e f, input logic [1:0] idx);
      case (f)
         FMT_B8_MONO:   lane_code = 2'b11;
         FMT_B8_STEREO: lane_code = {idx == 2'd0, 1'b1};
         FMT_B16_MONO:  lane_code = {1'b1, idx[0]};
         default:       lane_code = {~idx[1], idx[0]};
      endcase
   endfunction
endpackage

// File: rtl/pio_play_path.sv
module pio_play_path
   import pio_seq_pkg::*;
#(
   parameter int SET_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hold,
   input  logic                        en,
   input  fmt_e                        fmt,
   input  logic                        wr,
   input  logic [BYTE_W-1:0]           wdata,
   input  logic                        strobe,
   output logic                        rdy,
   output logic                        lr,
   output logic                        ul,
   output logic                        underrun,
   output logic [SET_BYTES*BYTE_W-1:0] frame,
   output logic                        vld
);
   localparam int IDX_W = $clog2(SET_BYTES);

   logic [IDX_W-1:0]            ptr_q;
   logic                        full_q;
   logic [SET_BYTES*BYTE_W-1:0] lanes_w;
   logic                        fire, take, last;
   logic [2:0]                  len;

   assign len      = frame_len(fmt);
   assign last     = ({1'b0, ptr_q} == len - 3'd1);
   assign rdy      = en & ~hold & ~full_q;
   assign fire     = strobe & en & ~hold;
   assign take     = wr & rdy & ~fire;
   assign underrun = fire & ~full_q;
   assign {lr, ul} = lane_code(fmt, ptr_q);

   for (genvar g = 0; g < SET_BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 q <= '0;
         else if (hold || fire)      q <= '0;
         else if (take && ptr_q == IDX_W'(g)) q <= wdata;
      end
      assign lanes_w[g*BYTE_W +: BYTE_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         full_q <= 1'b0;
         frame  <= '0;
         vld    <= 1'b0;
      end else if (hold) begin
         ptr_q  <= '0;
         full_q <= 1'b0;
         frame  <= '0;
         vld    <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (fire) begin
            ptr_q  <= '0;
            full_q <= 1'b0;
            if (full_q) begin
               frame <= lanes_w;
               vld   <= 1'b1;
            end
         end else if (take) begin
            if (last) begin
               ptr_q  <= '0;
               full_q <= 1'b1;
            end else begin
               ptr_q <= ptr_q + 1'b1;
            end
         end
      end
   end

   AST_PLAY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last) |=> !rdy); // R3
   AST_PLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (ptr_q == '0) && !vld); // R9
   AST_PLAY_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !vld && (ptr_q == '0)); // R6
endmodule

// File: rtl/pio_cap_path.sv
module pio_cap_path
   import pio_seq_pkg::*;
#(
   parameter int SET_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hold,
   input  logic                        en,
   input  fmt_e                        fmt,
   input  logic                        rd,
   input  logic                        strobe,
   input  logic [SET_BYTES*BYTE_W-1:0] frame_in,
   output logic                        rdy,
   output logic                        lr,
   output logic                        ul,
   output logic                        overrun,
   output logic [BYTE_W-1:0]           rdata
);
   localparam int IDX_W = $clog2(SET_BYTES);

   logic [IDX_W-1:0]            ptr_q;
   logic                        pend_q;
   logic [SET_BYTES*BYTE_W-1:0] buf_q;
   logic [BYTE_W-1:0]           lane_w [SET_BYTES];
   logic                        load, last;
   logic [2:0]                  len;

   assign len      = frame_len(fmt);
   assign last     = ({1'b0, ptr_q} == len - 3'd1);
   assign load     = strobe & en & ~hold;
   assign overrun  = load & pend_q;
   assign rdy      = pend_q & ~hold;
   assign {lr, ul} = lane_code(fmt, ptr_q);

   for (genvar g = 0; g < SET_BYTES; g++) begin : g_sel
      assign lane_w[g] = buf_q[g*BYTE_W +: BYTE_W];
   end
   assign rdata = lane_w[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         pend_q <= 1'b0;
         buf_q  <= '0;
      end else if (hold) begin
         ptr_q  <= '0;
         pend_q <= 1'b0;
         buf_q  <= '0;
      end else if (load) begin
         buf_q  <= frame_in;
         pend_q <= 1'b1;
         ptr_q  <= '0;
      end else if (rd && pend_q) begin
         if (last) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
         end else begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> pend_q && (ptr_q == '0)); // R5
   AST_CAP_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> pend_q && (ptr_q == '0)); // R7
   AST_CAP_STALE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && !load) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/pio_err_track.sv
module pio_err_track #(
   parameter int SRC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             clr,
   input  logic [SRC_N-1:0] hit,
   output logic [SRC_N-1:0] flag
);
   for (genvar s = 0; s < SRC_N; s++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[s] <= 1'b0;
         else if (hold)   flag[s] <= 1'b0;
         else if (hit[s]) flag[s] <= 1'b1;
         else if (clr)    flag[s] <= 1'b0;
      end

      AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[s] && !clr && !hold) |=> flag[s]); // R8
      AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[s] && !hold) |=> flag[s]); // R8
   end
endmodule

// File: rtl/pio_seq_stat.sv
module pio_seq_stat
   import pio_seq_pkg::*;
#(
   parameter int              SET_BYTES = 4,
   parameter int              BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] IDLE_READ = 8'h80
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hold,
   input  logic                        fmt_adpcm,
   input  logic                        fmt_wide,
   input  logic                        fmt_stereo,
   input  logic                        play_en,
   input  logic                        cap_en,
   input  logic                        play_strobe,
   input  logic                        cap_strobe,
   input  logic [SET_BYTES*BYTE_W-1:0] cap_frame,
   input  logic                        host_wr,
   input  logic                        host_rd,
   input  logic [BYTE_W-1:0]           host_wdata,
   output logic [BYTE_W-1:0]           host_rdata,
   input  logic                        stat_wr,
   output logic                        play_rdy,
   output logic                        play_lr,
   output logic                        play_ul,
   output logic                        cap_rdy,
   output logic                        cap_lr,
   output logic                        cap_ul,
   output logic                        smp_err,
   output logic                        err_play,
   output logic                        err_cap,
   output logic [SET_BYTES*BYTE_W-1:0] play_frame,
   output logic                        play_vld
);
   if (SET_BYTES != 4) begin : g_bad_set
      $error("SET_BYTES must be 4: the widest frame holds four bytes");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("BYTE_W must be positive");
   end

   fmt_e                fmt;
   logic                underrun, overrun;
   logic [BYTE_W-1:0]   cap_byte;
   logic [1:0]          flags;

   always_comb begin
      if (fmt_adpcm) fmt = FMT_PACK4;
      else case ({fmt_wide, fmt_stereo})
         2'b00:   fmt = FMT_B8_MONO;
         2'b01:   fmt = FMT_B8_STEREO;
         2'b10:   fmt = FMT_B16_MONO;
         default: fmt = FMT_B16_STEREO;
      endcase
   end

   pio_play_path #(.SET_BYTES(SET_BYTES), .BYTE_W(BYTE_W)) u_play (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .en       (play_en),
      .fmt      (fmt),
      .wr       (host_wr),
      .wdata    (host_wdata),
      .strobe   (play_strobe),
      .rdy      (play_rdy),
      .lr       (play_lr),
      .ul       (play_ul),
      .underrun (underrun),
      .frame    (play_frame),
      .vld      (play_vld)
   );

   pio_cap_path #(.SET_BYTES(SET_BYTES), .BYTE_W(BYTE_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .en       (cap_en),
      .fmt      (fmt),
      .rd       (host_rd),
      .strobe   (cap_strobe),
      .frame_in (cap_frame),
      .rdy      (cap_rdy),
      .lr       (cap_lr),
      .ul       (cap_ul),
      .overrun  (overrun),
      .rdata    (cap_byte)
   );

   pio_err_track #(.SRC_N(2)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .clr   (stat_wr),
      .hit   ({overrun, underrun}),
      .flag  (flags)
   );

   assign err_play   = flags[0];
   assign err_cap    = flags[1];
   assign smp_err    = |flags;
   assign host_rdata = hold ? IDLE_READ : cap_byte;

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!play_en && !err_play) |=> !err_play); // R11
   AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !play_rdy && !cap_rdy); // R9
endmodule

// File: tb/pio_seq_stat_bench.sv
module pio_seq_stat_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0, fmt_adpcm = 1'b0, fmt_wide = 1'b0, fmt_stereo = 1'b0;
   logic        play_en = 1'b0, cap_en = 1'b0, play_strobe = 1'b0, cap_strobe = 1'b0;
   logic [31:0] cap_frame = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0, stat_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        play_rdy, play_lr, play_ul, cap_rdy, cap_lr, cap_ul;
   logic        smp_err, err_play, err_cap, play_vld;
   logic [31:0] play_frame;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_seq_stat u_pio_seq_stat (
      .clk(clk), .rst_n(rst_n), .hold(hold), .fmt_adpcm(fmt_adpcm),
      .fmt_wide(fmt_wide), .fmt_stereo(fmt_stereo), .play_en(play_en),
      .cap_en(cap_en), .play_strobe(play_strobe), .cap_strobe(cap_strobe),
      .cap_frame(cap_frame), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .stat_wr(stat_wr),
      .play_rdy(play_rdy), .play_lr(play_lr), .play_ul(play_ul),
      .cap_rdy(cap_rdy), .cap_lr(cap_lr), .cap_ul(cap_ul), .smp_err(smp_err),
      .err_play(err_play), .err_cap(err_cap), .play_frame(play_frame),
      .play_vld(play_vld)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock edge; inputs change and outputs are sampled 1 time unit after it
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int exp_len(input int f);
      return (f == 0) ? 1 : (f < 3) ? 2 : 4;
   endfunction

   function automatic logic [1:0] exp_code(input int f, input int i);
      case (f)
         0:       return 2'b11;
         1:       return {i == 0, 1'b1};
         2:       return {1'b1, i[0]};
         default: return {i < 2, i[0]};
      endcase
   endfunction

   task automatic set_fmt(input int f);
      hold = 1'b1;
      tick();
      fmt_adpcm  = (f == 4);
      fmt_wide   = (f == 2 || f == 3);
      fmt_stereo = (f == 1 || f == 3);
      hold = 1'b0;
      tick();
   endtask

   task automatic wr_byte(input logic [7:0] b);
      host_wr = 1'b1; host_wdata = b;
      tick();
      host_wr = 1'b0;
   endtask

   task automatic rd_byte();
      host_rd = 1'b1;
      tick();
      host_rd = 1'b0;
   endtask

   task automatic pstrobe();
      play_strobe = 1'b1;
      tick();
      play_strobe = 1'b0;
   endtask

   task automatic cstrobe(input logic [31:0] v);
      cap_frame = v; cap_strobe = 1'b1;
      tick();
      cap_strobe = 1'b0;
   endtask

   initial begin
      tick();
      chk(play_rdy == 1'b0 && cap_rdy == 1'b0 && smp_err == 1'b0, "R9 reset", {play_rdy, cap_rdy, smp_err}, 0);
      rst_n = 1'b1;
      play_en = 1'b1; cap_en = 1'b1;
      tick();

      // sweep over all five formats, both directions
      for (int f = 0; f < 5; f++) begin
         logic [31:0] expf;
         logic [31:0] cv;
         set_fmt(f);
         expf = '0;
         for (int i = 0; i < exp_len(f); i++) begin
            logic [7:0] b;
            b = 8'(16 * f + i + 1);
            chk(play_rdy == 1'b1, "R3 ready while filling", play_rdy, 1);
            chk({play_lr, play_ul} == exp_code(f, i), "R1 playback code", {play_lr, play_ul}, exp_code(f, i));
            expf[8*i +: 8] = b;
            wr_byte(b);
         end
         chk(play_rdy == 1'b0, "R4 frame full after length", play_rdy, 0);
         wr_byte(8'hEE); // R10: ignored when full
         pstrobe();
         chk(play_vld == 1'b1, "R3 vld pulse", play_vld, 1);
         chk(play_frame == expf, "R3 R10 frame content", play_frame, expf);
         tick();
         chk(play_vld == 1'b0 && play_rdy == 1'b1, "R3 vld one cycle", {play_vld, play_rdy}, 1);
         chk({play_lr, play_ul} == exp_code(f, 0), "R4 wrap to byte 0", {play_lr, play_ul}, exp_code(f, 0));

         cv = 32'hA1B2C3D4 ^ (32'h01010101 * f);
         cstrobe(cv);
         for (int i = 0; i < exp_len(f); i++) begin
            chk(cap_rdy == 1'b1, "R5 capture ready", cap_rdy, 1);
            chk({cap_lr, cap_ul} == exp_code(f, i), "R2 capture code", {cap_lr, cap_ul}, exp_code(f, i));
            chk(host_rdata == cv[8*i +: 8], "R5 capture byte", host_rdata, cv[8*i +: 8]);
            rd_byte();
         end
         chk(cap_rdy == 1'b0, "R5 stale after last", cap_rdy, 0);
         rd_byte();
         chk(host_rdata == cv[7:0], "R5 stale read does not advance", host_rdata, cv[7:0]);
         chk(smp_err == 1'b0, "R8 no error in clean sweep", smp_err, 0);
      end

      // 16-bit stereo for the corner cases
      set_fmt(3);

      // R6 underrun after a partial frame
      wr_byte(8'h55);
      pstrobe();
      chk(err_play == 1'b1 && smp_err == 1'b1 && err_cap == 1'b0, "R6 underrun flags", {err_play, smp_err, err_cap}, 3'b110);
      chk(play_vld == 1'b0, "R6 no vld on underrun", play_vld, 0);
      chk({play_lr, play_ul} == 2'b10, "R6 pointer restarts", {play_lr, play_ul}, 2'b10);
      for (int i = 0; i < 4; i++) wr_byte(8'(8'h60 + i));
      pstrobe();
      chk(play_frame == 32'h63626160, "R6 partial discarded", play_frame, 32'h63626160);
      chk(err_play == 1'b1, "R8 sticky", err_play, 1);

      // R7 overrun mid-frame
      cstrobe(32'h11223344);
      rd_byte();
      cstrobe(32'h99887766);
      chk(err_cap == 1'b1 && smp_err == 1'b1, "R7 overrun flags", {err_cap, smp_err}, 2'b11);
      chk(host_rdata == 8'h66 && cap_ul == 1'b0 && cap_lr == 1'b1, "R7 new frame byte 0", host_rdata, 8'h66);

      // R8 clear, then clear colliding with a new underrun
      stat_wr = 1'b1;
      tick();
      stat_wr = 1'b0;
      chk(err_play == 1'b0 && err_cap == 1'b0 && smp_err == 1'b0, "R8 clear", {err_play, err_cap, smp_err}, 0);
      stat_wr = 1'b1; play_strobe = 1'b1;
      tick();
      stat_wr = 1'b0; play_strobe = 1'b0;
      chk(err_play == 1'b1, "R8 new error wins over clear", err_play, 1);

      // R10 write in the same cycle as a strobe is dropped
      host_wr = 1'b1; host_wdata = 8'hAB; play_strobe = 1'b1;
      tick();
      host_wr = 1'b0; play_strobe = 1'b0;
      chk({play_lr, play_ul} == 2'b10, "R10 write with strobe dropped", {play_lr, play_ul}, 2'b10);

      // R9 hold: partial state, then hold
      wr_byte(8'h01);
      cstrobe(32'hCAFEF00D);
      hold = 1'b1;
      #1;
      chk(host_rdata == 8'h80, "R9 idle read", host_rdata, 8'h80);
      chk(play_rdy == 1'b0 && cap_rdy == 1'b0, "R9 not ready", {play_rdy, cap_rdy}, 0);
      wr_byte(8'hDD);
      cstrobe(32'h12345678);
      pstrobe();
      chk(err_play == 1'b0 && err_cap == 1'b0, "R9 errors cleared", {err_play, err_cap}, 0);
      hold = 1'b0;
      tick();
      chk(cap_rdy == 1'b0, "R9 strobe ignored in hold", cap_rdy, 0);
      chk({play_lr, play_ul} == 2'b10 && play_rdy == 1'b1, "R9 pointer cleared", {play_lr, play_ul, play_rdy}, 3'b101);
      for (int i = 0; i < 4; i++) wr_byte(8'(8'hC0 + i));
      pstrobe();
      chk(play_frame == 32'hC3C2C1C0, "R9 write in hold ignored", play_frame, 32'hC3C2C1C0);

      // R11 disabled directions
      play_en = 1'b0; cap_en = 1'b0;
      tick();
      pstrobe();
      cstrobe(32'h0BADBEEF);
      chk(err_play == 1'b0 && cap_rdy == 1'b0 && play_rdy == 1'b0, "R11 disabled strobes", {err_play, cap_rdy, play_rdy}, 0);
      wr_byte(8'h77);
      play_en = 1'b1;
      tick();
      chk({play_lr, play_ul} == 2'b10, "R11 R10 write while disabled ignored", {play_lr, play_ul}, 2'b10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule